// File: doc/BRIEF.md
# Programmable 5-bit PWM generator

This block drives one pulse-width-modulated line from a stored 5-bit duty code. A prescaler outside the block supplies a one-cycle tick. Every 32 ticks form one output period. Within a period the output is high for as many ticks as the duty code says. A code of zero keeps the line low. The largest code keeps it high for 31 of the 32 ticks. A separate full-on command holds the line high for the whole period.

Commands arrive as single-cycle strobes:

- **Set-duty** stores a new code and cancels full-on.
- **Set-full-on** turns on full-on and keeps the stored code.
- **Shutdown** releases the output pad.
- **Recall** brings the output back, using whatever setting is stored at that moment.

A new setting first goes into a stored (shadow) copy. The running setting picks it up only at the end of a period, so no period is cut short. The stored setting, the full-on flag and the shutdown flag can be read back at any time.

There is no data stream in this block. Every pin is a plain control or status signal. No pin has back-pressure and none has a handshake. After reset the code is 16, so the block runs as a 50% oscillator with no setup.

Top module: `pwm5_gen`

## Requirements
- R1: After reset the stored code is 5'b10000, full-on and shutdown are both 0, `pwm_oe` is 1, and the output is high for 16 of every 32 ticks.
- R2: With full-on off and the pad enabled, `pwm_out` is high for exactly N ticks out of each 32-tick period, where N is the duty code. A code of 0 gives a line that is always low, and code 31 gives 31 high ticks.
- R3: When full-on is active and the pad is enabled, `pwm_out` stays high. Set-full-on does not change the stored 5-bit code.
- R4: Set-duty clears the full-on flag. When set-duty and set-full-on are strobed in the same cycle, the code from `duty_in` is stored and full-on ends up set.
- R5: While in shutdown, `pwm_oe` is 0 and `pwm_out` is held at 0.
- R6: Recall leaves shutdown, and the output then follows the stored setting.
- R7: Set-duty and set-full-on strobed during shutdown update the stored setting and the status outputs, but leave `pwm_oe` at 0.
- R8: The running setting changes only in the clock cycle after a tick that ends a period, that is, a tick arriving at phase 31. A new setting reaches the output within two periods of its command.
- R9: The phase advances only on a tick. With a tick every K cycles, the output is high for N·K of every 32·K cycles.
- R10: When shutdown and recall are strobed in the same cycle, shutdown wins.
- R11: The status outputs `stat_duty`, `stat_full` and `stat_shdn` show the stored code, full-on flag and shutdown flag one cycle after the command that changed them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaler tick; one period is 32 ticks |
| duty_in | input | 5 | Duty code for set-duty |
| set_duty | input | 1 | Strobe: store `duty_in` as the code and clear full-on |
| set_full | input | 1 | Strobe: turn on full-on |
| shutdown | input | 1 | Strobe: enter shutdown |
| recall | input | 1 | Strobe: leave shutdown |
| pwm_out | output | 1 | PWM level, 0 while in shutdown |
| pwm_oe | output | 1 | Output enable for the tri-state pad |
| stat_duty | output | 5 | Stored duty code |
| stat_full | output | 1 | Stored full-on flag |
| stat_shdn | output | 1 | Shutdown flag |

## Verification
The hardest case to reach is a setting that changes while the pad is released. The output shows nothing during shutdown, so the new setting can only be seen once the block has been recalled. The stimulus therefore enters shutdown, confirms that the pad is released, stores a new code and checks it through the status outputs. It then recalls the block, waits two periods and counts high ticks over one full period. The same-cycle collisions (set-duty with set-full-on, and shutdown with recall) are driven directly. A slower tick rate is also run, to show that the phase holds between ticks.

// File: rtl/pwm5_pkg.sv
package pwm5_pkg;
  localparam int DUTY_W = 5;

  // Duty code loaded at reset: half scale.
  function automatic logic [DUTY_W-1:0] half_code();
    return DUTY_W'(1) << (DUTY_W - 1);
  endfunction
endpackage

// File: rtl/pwm5_cfg.sv
module pwm5_cfg
  import pwm5_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic              set_duty,
  input  logic              set_full,
  input  logic              shutdown,
  input  logic              recall,
  output logic [DUTY_W-1:0] code_q,
  output logic              full_q,
  output logic              shdn_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= half_code();
      full_q <= 1'b0;
      shdn_q <= 1'b0;
    end else begin
      if (set_duty) begin
        code_q <= duty_in;
        full_q <= 1'b0;
      end
      if (set_full) full_q <= 1'b1;   // last write wins over set_duty
      if (shutdown)    shdn_q <= 1'b1;
      else if (recall) shdn_q <= 1'b0;
    end
  end

  a_r4_clear_full: assert property (@(posedge clk) disable iff (!rst_n)
    (set_duty && !set_full) |=> !full_q);
  a_r10_shdn_wins: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> shdn_q);
  a_r3_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (set_full && !set_duty) |=> $stable(code_q));
endmodule

// File: rtl/pwm5_phase.sv
module pwm5_phase
  import pwm5_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic [DUTY_W-1:0] phase,
  output logic              wrap
);
  localparam logic [DUTY_W-1:0] LAST = '1;

  assign wrap = tick && (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (tick) phase <= phase + 1'b1;
  end

  a_r9_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase));
endmodule

// File: rtl/pwm5_out.sv
module pwm5_out
  import pwm5_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap,
  input  logic [DUTY_W-1:0] phase,
  input  logic [DUTY_W-1:0] code,
  input  logic              full,
  input  logic              shdn,
  output logic [DUTY_W-1:0] act_code,
  output logic              act_full,
  output logic              pwm_out,
  output logic              pwm_oe
);
  logic level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_code <= half_code();
      act_full <= 1'b0;
    end else if (wrap) begin
      act_code <= code;
      act_full <= full;
    end
  end

  assign level   = act_full || (phase < act_code);
  assign pwm_oe  = !shdn;
  assign pwm_out = level && !shdn;

  a_r2_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code == '0 && !act_full) |-> !pwm_out);
endmodule

// File: rtl/pwm5_gen.sv
module pwm5_gen
  import pwm5_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic              set_duty,
  input  logic              set_full,
  input  logic              shutdown,
  input  logic              recall,
  output logic              pwm_out,
  output logic              pwm_oe,
  output logic [DUTY_W-1:0] stat_duty,
  output logic              stat_full,
  output logic              stat_shdn
);
  localparam logic [DUTY_W-1:0] LAST = '1;

  logic [DUTY_W-1:0] phase, act_code;
  logic              wrap, act_full;

  pwm5_cfg u_cfg (
    .clk, .rst_n, .duty_in, .set_duty, .set_full, .shutdown, .recall,
    .code_q(stat_duty), .full_q(stat_full), .shdn_q(stat_shdn)
  );

  pwm5_phase u_phase (.clk, .rst_n, .tick, .phase, .wrap);

  pwm5_out u_out (
    .clk, .rst_n, .wrap, .phase, .code(stat_duty), .full(stat_full),
    .shdn(stat_shdn), .act_code, .act_full, .pwm_out, .pwm_oe
  );

  a_r8_load_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && phase == LAST) |=> ($stable(act_code) && $stable(act_full)));
  a_r5_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    stat_shdn |-> (!pwm_oe && !pwm_out));
  a_r3_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (act_full && !stat_shdn) |-> pwm_out);
endmodule

// File: tb/sim_pwm5_gen.sv
`timescale 1ns/1ps
module sim_pwm5_gen;
  logic clk = 1'b0, rst_n = 1'b0, tick;
  logic [4:0] duty_in = '0;
  logic set_duty = 0, set_full = 0, shutdown = 0, recall = 0;
  logic pwm_out, pwm_oe, stat_full, stat_shdn;
  logic [4:0] stat_duty;
  int checks = 0, fails = 0;
  int tick_div = 1, tick_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm5_gen u0 (.clk, .rst_n, .tick, .duty_in, .set_duty, .set_full, .shutdown,
    .recall, .pwm_out, .pwm_oe, .stat_duty, .stat_full, .stat_shdn);

  // Tick generator, updated away from the active edge.
  assign tick = (tick_cnt == 0);
  always @(negedge clk) tick_cnt <= (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;

  // {full, duty[4:0], expected high ticks[5:0]}
  localparam logic [11:0] VEC [0:5] = '{
    {1'b0, 5'd0,  6'd0},  {1'b0, 5'd31, 6'd31}, {1'b0, 5'd1, 6'd1},
    {1'b1, 5'd7,  6'd32}, {1'b0, 5'd5,  6'd5},  {1'b1, 5'd31, 6'd32}};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input bit d, input bit f, input bit s, input bit r, input logic [4:0] v);
    @(negedge clk);
    duty_in = v; set_duty = d; set_full = f; shutdown = s; recall = r;
    @(negedge clk);
    set_duty = 0; set_full = 0; shutdown = 0; recall = 0;
  endtask

  task automatic wait_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  initial begin
    int hi;
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int hi;
    wait_cycles(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 code", stat_duty, 16);
    check("R1 full", stat_full, 0);
    check("R1 shdn", stat_shdn, 0);
    check("R1 oe", pwm_oe, 1);
    measure(32, hi); check("R1 duty", hi, 16);

    // R2 / R3 / R8 / R11 vector walk
    foreach (VEC[i]) begin
      strobe(1, 0, 0, 0, VEC[i][10:6]);
      if (VEC[i][11]) strobe(0, 1, 0, 0, 5'd0);
      check("R11 stat_duty", stat_duty, VEC[i][10:6]);
      check("R11 stat_full", stat_full, VEC[i][11]);
      wait_cycles(64);                       // R8: two periods
      measure(32, hi);
      check(VEC[i][11] ? "R3 full-on" : "R2 duty", hi, VEC[i][5:0]);
    end

    // R4 set-duty clears full-on
    strobe(1, 0, 0, 0, 5'd12);
    check("R4 full cleared", stat_full, 0);
    wait_cycles(64); measure(32, hi); check("R4 duty", hi, 12);
    // R4 same-cycle set-duty and set-full
    strobe(1, 1, 0, 0, 5'd9);
    check("R4 both code", stat_duty, 9);
    check("R4 both full", stat_full, 1);
    strobe(1, 0, 0, 0, 5'd20);

    // R5 shutdown
    strobe(0, 0, 1, 0, 5'd0);
    check("R5 oe", pwm_oe, 0);
    check("R5 shdn", stat_shdn, 1);
    measure(64, hi); check("R5 out low", hi, 0);
    // R7 commands during shutdown
    strobe(1, 0, 0, 0, 5'd3);
    check("R7 stat_duty", stat_duty, 3);
    check("R7 oe", pwm_oe, 0);
    measure(64, hi); check("R7 out low", hi, 0);
    // R10 shutdown beats recall
    strobe(0, 0, 1, 1, 5'd0);
    check("R10 shdn", stat_shdn, 1);
    // R6 recall
    strobe(0, 0, 0, 1, 5'd0);
    check("R6 oe", pwm_oe, 1);
    check("R6 shdn", stat_shdn, 0);
    wait_cycles(64); measure(32, hi); check("R6 duty", hi, 3);
    // R3 full-on keeps code through shutdown
    strobe(0, 1, 1, 0, 5'd0);
    check("R3 code kept", stat_duty, 3);
    strobe(0, 0, 0, 1, 5'd0);
    wait_cycles(64); measure(32, hi); check("R3 full after recall", hi, 32);

    // R9 slower tick
    strobe(1, 0, 0, 0, 5'd10);
    tick_div = 3;
    wait_cycles(200); measure(96, hi); check("R9 slow tick", hi, 30);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule